// File: doc/BRIEF.md
# Dual-Map Register Rename Unit

This unit translates architectural register numbers into physical register tags for an out-of-order core. It keeps two alias tables. The speculative table is written as instructions pass through rename. The committed table is written as instructions retire. A bit-vector free list supplies new physical tags to destinations and takes back the tags that retirement makes stale.

Each cycle a rename group of up to `RN_W` instructions is offered. Every instruction has two source indices and an optional destination. The unit returns the physical tag for each source and a new tag for each destination. It also returns the tag the destination held before, so that later stages can order the release. Retirement updates only the committed map; no register value moves. A flush rebuilds the speculative state from the committed state in one cycle.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i in both alias tables. Tags NUM_ARCH to NUM_PHYS-1 are free, and tags 0 to NUM_ARCH-1 are not free.
- R2: A source tag output is combinational and equals the current speculative mapping of the source index, unless R4 applies.
- R3: When a rename fires, each lane with a destination receives the lowest-numbered free tag not already given to a lower-numbered lane. The lane's stale output is the previous speculative mapping of its destination. The speculative table then maps that destination to the new tag, and the new tag leaves the free list.
- R4: Within one group, a source in lane j that names a register written by a lower lane sees the tag of the highest such lower lane. The stale output of lane j follows the same rule.
- R5: `rn_ready` is low when fewer tags are free than the group has valid destinations, and whenever `flush` is high. A rename fires only while `rn_ready` is high. A group offered while `rn_ready` is low changes no state.
- R6: Up to RT_W retirements are applied per cycle, in lane order. Each points the committed entry of its architectural register at the retiring tag and returns the tag that entry held to the free list. Register data is never touched.
- R7: On flush, the speculative table takes the committed table as it stands after that cycle's retirements. The free list becomes every tag that the committed table does not reference.
- R8: No tag is handed out while it is not free, and two lanes of one group never receive the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore speculative state from committed state |
| rn_valid | input | RN_W | Lane holds an instruction |
| rn_dst_vld | input | RN_W | Lane writes a destination |
| rn_src_a | input | RN_W*AW | First source index per lane |
| rn_src_b | input | RN_W*AW | Second source index per lane |
| rn_dst | input | RN_W*AW | Destination index per lane |
| rn_ready | output | 1 | Group accepted this cycle |
| rn_src_a_tag | output | RN_W*PW | Physical tag of first source |
| rn_src_b_tag | output | RN_W*PW | Physical tag of second source |
| rn_dst_tag | output | RN_W*PW | Newly allocated destination tag |
| rn_stale_tag | output | RN_W*PW | Previous mapping of the destination |
| rt_valid | input | RT_W | Retire lane active |
| rt_dst | input | RT_W*AW | Architectural register being committed |
| rt_new_tag | input | RT_W*PW | Physical tag being committed |

## Verification
The embedded assertions check on every cycle that allocated tags are free, that lanes never share a tag, that a committed tag is not free, that the free count stays within its bound, and that the speculative map equals the committed map after a flush. Lowest-free allocation order, intra-group forwarding, stalling on an exhausted free list, and the effect of retirement on the committed map only show in the bench scenarios. Retirement is observed through a later flush followed by source lookups.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 128,
  parameter int RN_W     = 2,
  parameter int RT_W     = 3,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [RN_W-1:0]    rn_valid,
  input  logic [RN_W-1:0]    rn_dst_vld,
  input  logic [RN_W*AW-1:0] rn_src_a,
  input  logic [RN_W*AW-1:0] rn_src_b,
  input  logic [RN_W*AW-1:0] rn_dst,
  output logic               rn_ready,
  output logic [RN_W*PW-1:0] rn_src_a_tag,
  output logic [RN_W*PW-1:0] rn_src_b_tag,
  output logic [RN_W*PW-1:0] rn_dst_tag,
  output logic [RN_W*PW-1:0] rn_stale_tag,
  input  logic [RT_W-1:0]    rt_valid,
  input  logic [RT_W*AW-1:0] rt_dst,
  input  logic [RT_W*PW-1:0] rt_new_tag
);

  logic [PW-1:0] fe_q [NUM_ARCH];
  logic [PW-1:0] rt_q [NUM_ARCH];
  logic [NUM_PHYS-1:0] free_q;

  logic [PW-1:0] fe_view [NUM_ARCH];
  logic [PW-1:0] rt_view [NUM_ARCH];
  logic [NUM_PHYS-1:0] avail, released, committed, free_nxt;
  logic [RN_W-1:0] need;
  logic alloc_ok;
  logic fire;

  function automatic logic [PW:0] lowest_free(input logic [NUM_PHYS-1:0] v);
    logic [PW:0] r;
    r = '0;
    for (int p = NUM_PHYS - 1; p >= 0; p--)
      if (v[p]) r = {1'b1, PW'(p)};
    return r;
  endfunction

  assign need     = rn_valid & rn_dst_vld;
  assign rn_ready = alloc_ok && !flush;
  assign fire     = rn_ready && (|rn_valid);

  always_comb begin
    logic [PW:0] pick;
    avail    = free_q;
    alloc_ok = 1'b1;
    fe_view  = fe_q;
    rn_src_a_tag = '0;
    rn_src_b_tag = '0;
    rn_dst_tag   = '0;
    rn_stale_tag = '0;
    for (int l = 0; l < RN_W; l++) begin
      pick = lowest_free(avail);
      rn_dst_tag[l*PW +: PW] = pick[PW-1:0];
      rn_src_a_tag[l*PW +: PW] = fe_view[rn_src_a[l*AW +: AW]];
      rn_src_b_tag[l*PW +: PW] = fe_view[rn_src_b[l*AW +: AW]];
      rn_stale_tag[l*PW +: PW] = fe_view[rn_dst[l*AW +: AW]];
      if (need[l]) begin
        if (!pick[PW]) alloc_ok = 1'b0;
        avail[pick[PW-1:0]] = 1'b0;
        fe_view[rn_dst[l*AW +: AW]] = pick[PW-1:0];
      end
    end
  end

  always_comb begin
    rt_view  = rt_q;
    released = '0;
    for (int k = 0; k < RT_W; k++)
      if (rt_valid[k]) begin
        released[rt_view[rt_dst[k*AW +: AW]]] = 1'b1;
        rt_view[rt_dst[k*AW +: AW]] = rt_new_tag[k*PW +: PW];
      end
    committed = '0;
    for (int a = 0; a < NUM_ARCH; a++)
      committed[rt_view[a]] = 1'b1;
    if (flush)     free_nxt = ~committed;
    else if (fire) free_nxt = avail | released;
    else           free_nxt = free_q | released;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        fe_q[a] <= PW'(a);
        rt_q[a] <= PW'(a);
      end
      for (int p = 0; p < NUM_PHYS; p++)
        free_q[p] <= (p >= NUM_ARCH);
    end else begin
      rt_q   <= rt_view;
      free_q <= free_nxt;
      if (flush)     fe_q <= rt_view;
      else if (fire) fe_q <= fe_view;
    end
  end

  logic [NUM_ARCH*PW-1:0] fe_flat, rt_flat;
  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_flat
    assign fe_flat[a*PW +: PW] = fe_q[a];
    assign rt_flat[a*PW +: PW] = rt_q[a];
  end

  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fe_flat == rt_flat)); // R7

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_q) <= NUM_PHYS - NUM_ARCH); // R6

  for (genvar l = 0; l < RN_W; l++) begin : g_rn_chk
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_ready && need[l]) |-> free_q[rn_dst_tag[l*PW +: PW]]); // R8
    for (genvar j = l + 1; j < RN_W; j++) begin : g_pair
      AST_ALLOC_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_ready && need[l] && need[j]) |->
        (rn_dst_tag[l*PW +: PW] != rn_dst_tag[j*PW +: PW])); // R8
    end
  end

  for (genvar k = 0; k < RT_W; k++) begin : g_rt_chk
    AST_RETIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rt_valid[k] |-> !free_q[rt_new_tag[k*PW +: PW]]); // R6
  end

endmodule

// File: tb/rename_map_tb.sv
`timescale 1ns/1ps
module rename_map_tb;
  localparam int NA = 8, NP = 128, RN = 2, RT = 3, AW = 3, PW = 7;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [RN-1:0] v = '0, dv = '0;
  logic [AW-1:0] sa [RN], sb [RN], d [RN];
  logic [RT-1:0] rv = '0;
  logic [AW-1:0] ra [RT];
  logic [PW-1:0] rtag [RT];
  logic [RN*AW-1:0] sa_f, sb_f, d_f;
  logic [RT*AW-1:0] ra_f;
  logic [RT*PW-1:0] rt_f;
  logic rdy;
  logic [RN*PW-1:0] ta, tb, td, ts;

  always #4 clk = ~clk;

  for (genvar l = 0; l < RN; l++) begin : g_in
    assign sa_f[l*AW +: AW] = sa[l];
    assign sb_f[l*AW +: AW] = sb[l];
    assign d_f[l*AW +: AW]  = d[l];
  end
  for (genvar k = 0; k < RT; k++) begin : g_rt
    assign ra_f[k*AW +: AW] = ra[k];
    assign rt_f[k*PW +: PW] = rtag[k];
  end

  rename_map u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rn_valid(v), .rn_dst_vld(dv), .rn_src_a(sa_f), .rn_src_b(sb_f), .rn_dst(d_f),
    .rn_ready(rdy), .rn_src_a_tag(ta), .rn_src_b_tag(tb), .rn_dst_tag(td), .rn_stale_tag(ts),
    .rt_valid(rv), .rt_dst(ra_f), .rt_new_tag(rt_f));

  int fe [NA], rtm [NA];
  bit fr [NP];
  int q_a [256], q_t [256];
  int qh = 0, qt = 0;
  int nchk = 0, nerr = 0;
  int ea [RN];
  bit exp_rdy;
  int nret;
  string src_tag = "";
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < NA; a++) begin fe[a] = a; rtm[a] = a; end
    for (int p = 0; p < NP; p++) fr[p] = (p >= NA);
    qh = 0; qt = 0;
  endtask

  task automatic predict_and_check();
    int cnt, nd;
    bit av [NP];
    int view [NA];
    bit byp [NA];
    cnt = 0; nd = 0;
    for (int p = 0; p < NP; p++) begin av[p] = fr[p]; cnt += fr[p]; end
    for (int l = 0; l < RN; l++) nd += (v[l] && dv[l]);
    exp_rdy = !flush && cnt >= nd;
    chk("R5", int'(rdy), int'(exp_rdy));
    for (int a = 0; a < NA; a++) begin view[a] = fe[a]; byp[a] = 0; end
    for (int l = 0; l < RN; l++) begin
      ea[l] = 0;
      for (int p = NP - 1; p >= 0; p--) if (av[p]) ea[l] = p;
      if (v[l] && !flush) begin
        if (!byp[sa[l]] || exp_rdy)
          chk(byp[sa[l]] ? "R4" : (src_tag != "" ? src_tag : "R2"), int'(ta[l*PW +: PW]), view[sa[l]]);
        if (!byp[sb[l]] || exp_rdy)
          chk(byp[sb[l]] ? "R4" : (src_tag != "" ? src_tag : "R2"), int'(tb[l*PW +: PW]), view[sb[l]]);
        if (dv[l] && exp_rdy) begin
          chk("R3", int'(td[l*PW +: PW]), ea[l]);
          chk(byp[d[l]] ? "R4" : "R3", int'(ts[l*PW +: PW]), view[d[l]]);
        end
      end
      if (v[l] && dv[l]) begin
        av[ea[l]] = 0;
        view[d[l]] = ea[l];
        byp[d[l]] = 1;
      end
    end
  endtask

  task automatic model_update();
    for (int k = 0; k < nret; k++) begin
      int a, t;
      a = q_a[qh % 256]; t = q_t[qh % 256];
      fr[rtm[a]] = 1;
      rtm[a] = t;
      qh++;
    end
    if (flush) begin
      for (int a = 0; a < NA; a++) fe[a] = rtm[a];
      for (int p = 0; p < NP; p++) fr[p] = 1;
      for (int a = 0; a < NA; a++) fr[rtm[a]] = 0;
      qh = qt;
    end else if (exp_rdy) begin
      for (int l = 0; l < RN; l++)
        if (v[l] && dv[l]) begin
          fe[d[l]] = ea[l];
          fr[ea[l]] = 0;
          q_a[qt % 256] = d[l]; q_t[qt % 256] = ea[l]; qt++;
        end
    end
  endtask

  task automatic cycle(bit fl, int want_ret, bit rn_on, bit need_dst);
    @(negedge clk);
    flush = fl;
    nret = want_ret;
    if (nret > qt - qh) nret = qt - qh;
    rv = '0;
    for (int k = 0; k < RT; k++) begin
      ra[k] = '0; rtag[k] = '0;
      if (k < nret) begin
        rv[k] = 1'b1;
        ra[k] = AW'(q_a[(qh + k) % 256]);
        rtag[k] = PW'(q_t[(qh + k) % 256]);
      end
    end
    for (int l = 0; l < RN; l++) begin
      v[l]  = rn_on && ($urandom % 4 != 0);
      dv[l] = need_dst ? 1'b1 : ($urandom % 3 != 0);
      sa[l] = AW'($urandom); sb[l] = AW'($urandom); d[l] = AW'($urandom);
    end
    if (need_dst) v = '1;
    #1;
    predict_and_check();
    @(posedge clk);
    model_update();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int l = 0; l < RN; l++) begin sa[l] = '0; sb[l] = '0; d[l] = '0; end
    for (int k = 0; k < RT; k++) begin ra[k] = '0; rtag[k] = '0; end
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: identity map and first allocation from tag NA
    @(negedge clk);
    v = '1; dv = '0;
    for (int a = 0; a < NA; a += 2) begin
      sa[0] = AW'(a); sb[0] = AW'(a + 1); sa[1] = AW'(a + 1); sb[1] = AW'(a);
      #1;
      chk("R1", int'(ta[PW-1:0]), a);
      chk("R1", int'(tb[PW-1:0]), a + 1);
      chk("R1", int'(ta[PW +: PW]), a + 1);
      @(negedge clk);
    end
    dv = 2'b01; d[0] = 3'd5; #1;
    chk("R1", int'(td[PW-1:0]), NA);
    chk("R1", int'(rdy), 1);
    v = '0; dv = '0;
    // R5: exhaust free list with no retirement
    for (int i = 0; i < 70; i++) cycle(0, 0, 1, 1);
    chk("R5", int'(rdy), 0);
    // R6: retire everything, then flush and read back committed map
    for (int i = 0; i < 50; i++) cycle(0, 3, 0, 0);
    cycle(1, 0, 0, 0);
    @(negedge clk);
    v = '1; dv = '0; rv = '0; flush = 0;
    for (int a = 0; a < NA; a++) begin
      sa[0] = AW'(a); #1;
      chk("R6", int'(ta[PW-1:0]), rtm[a]);
      @(negedge clk);
    end
    v = '0;
    // random mix with flushes (R2, R3, R4, R5, R7)
    for (int i = 0; i < 4000; i++) begin
      bit f;
      f = ($urandom % 50 == 0);
      src_tag = "";
      cycle(f, $urandom % 4, 1, 0);
      if (f) begin
        src_tag = "R7";
        cycle(0, 0, 1, 0);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule